// File: doc/BRIEF.md
# DMA Transfer Segment Splitter

This block turns one transfer request into a stream of segments, each an address and a byte count that fits the per-buffer count field of a DMA channel, which can hold at most 0x1FFF bytes. A request comes in over a valid/ready port. It either describes a single linear transfer as a start address and a byte length, or a cyclic ring buffer as a base address, a buffer size and a period length. Segments leave over a second valid/ready port. The consumer loads each segment into the next free hardware buffer of the channel.

When the bytes still owed exceed the limit, the block does not cut maximum-size pieces. It first works out how many pieces the remainder needs, given a step that is the limit with its two low bits cleared. It then divides the remainder by that count and clears the two low bits of the result. The pieces come out close to equal and stay word aligned, so no short tail fragment is left. All division goes through one shared iterative restoring divider, and the segment port stays idle while a quotient is being formed.

In cyclic mode each period is split with the same rule. The segment that finishes a period carries a period marker. After the last whole period in the buffer the address wraps back to the base, and the ring keeps running until a halt is given. Requests with a misaligned start address, or that would yield no segment at all, are refused with a one-cycle error pulse.

Top module: `seg_splitter`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request offered while segments are still pending is not taken.
- R2: Every offered segment has a length between 1 and 0x1FFF bytes.
- R3: When the bytes still owed (the rest of the transfer, or of the current period in cyclic mode) are at most 0x1FFF, they go out as one segment of exactly that length.
- R4: When the bytes owed, r, exceed 0x1FFF, the segment length is floor(r / m) with bits [1:0] cleared, where m = ceil(r / 0x1FFC).
- R5: The first segment starts at the request address. Each following segment starts at the previous address plus the previous length, and in linear mode the lengths add up to the requested length.
- R6: A request whose address has bit 1 or bit 0 set is refused. `req_err` is high for exactly one cycle after the request is taken, and no segment follows.
- R7: A linear request of length 0 is refused the same way. So is a cyclic request with period 0 or with size smaller than period.
- R8: `seg_last` is 1 on the final segment of a linear request and 0 on every other segment, including all cyclic ones.
- R9: In cyclic mode `seg_period` is 1 exactly on the segment that completes a period. Every period is split by the rules of R3 and R4.
- R10: In cyclic mode the buffer holds floor(size / period) periods. After the last one the next segment starts again at the base address, and any bytes beyond the last whole period are never covered.
- R11: A one-cycle pulse on `cyc_halt` during a cyclic run ends the run at the next segment hand-off: no segment is offered after it and `req_ready` returns high. In linear mode `cyc_halt` has no effect.
- R12: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len`, `seg_last` and `seg_period` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ADDR_W | Start address (base address in cyclic mode) |
| req_len | input | LEN_W | Transfer length, or buffer size in cyclic mode |
| req_cyclic | input | 1 | 1 selects cyclic ring mode |
| req_period | input | LEN_W | Period length in cyclic mode |
| cyc_halt | input | 1 | Ends a running cyclic transfer |
| req_err | output | 1 | One-cycle pulse: last request was refused |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | SEG_W | Segment length in bytes |
| seg_last | output | 1 | Final segment of a linear transfer |
| seg_period | output | 1 | Segment completes a cyclic period |

## Verification
Linear lengths of 0x100, exactly 0x1FFF, 0x2000 and 0x5000 cover the path with no division, the exact limit, a two-way split just above the limit, and a three-piece split whose pieces differ through alignment trimming. These show whether the divisor is recomputed for each piece. A cyclic ring whose periods must be split is set against a ring with unsplit periods and an unused tail. This shows whether period markers follow period completion and whether the wrap point comes from the whole-period count rather than the buffer size. Held-off consumption, halts given in both modes, and refused requests of each kind complete the set.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NPER = 3'd1,
    ST_CALC = 3'd2,
    ST_DIV1 = 3'd3,
    ST_DIV2 = 3'd4,
    ST_EMIT = 3'd5
  } seg_state_e;

endpackage

// File: rtl/seg_req_check.sv
module seg_req_check #(
  parameter int LEN_W      = 24,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ALIGN_BITS-1:0] addr_low,
  input  logic [LEN_W-1:0]      len,
  input  logic                  cyclic,
  input  logic [LEN_W-1:0]      period,
  output logic                  bad
);

  logic misaligned;
  logic empty_linear;
  logic empty_ring;

  always_comb begin
    misaligned   = |addr_low;
    empty_linear = !cyclic && (len == '0);
    empty_ring   = cyclic && ((period == '0) || (len < period));
    bad          = misaligned || empty_linear || empty_ring;
  end

endmodule

// File: rtl/seg_divider.sv
module seg_divider #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CNT_W = $clog2(W + 1);
  localparam int PW    = 2 * W;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [W:0]       part;
  logic [W-1:0]     quo;
  logic [W-1:0]     den;
  logic [W-1:0]     num_q;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    shifted = {part[W-1:0], quo[W-1]};
    diff    = shifted - {1'b0, den};
    fits    = !diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      part  <= '0;
      quo   <= '0;
      den   <= '0;
      num_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(W);
        part  <= '0;
        quo   <= dividend;
        den   <= divisor;
        num_q <= dividend;
      end else if (busy) begin
        part <= fits ? diff : shifted;
        quo  <= {quo[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  // R4: the quotient handed to the splitter is the exact floor quotient
  p_div_exact_r4: assert property (@(posedge clk) disable iff (rst)
    (done && den != '0) |->
      ((PW'(quotient) * PW'(den) <= PW'(num_q)) &&
       (PW'(num_q) - PW'(quotient) * PW'(den) < PW'(den))));

endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
  import seg_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int SEG_MAX    = 8191,
  parameter int ALIGN_BITS = 2,
  parameter int SEG_W      = $clog2(SEG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_cyclic,
  input  logic [LEN_W-1:0]  req_period,
  input  logic              cyc_halt,
  output logic              req_err,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [SEG_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              seg_period
);

  localparam int DIV_W = LEN_W + 1;
  localparam logic [DIV_W-1:0] ALIGN_MASK = DIV_W'((1 << ALIGN_BITS) - 1);
  localparam logic [DIV_W-1:0] SEG_STEP   = DIV_W'(SEG_MAX) & ~ALIGN_MASK;
  localparam logic [LEN_W-1:0] SEG_LIMIT  = LEN_W'(SEG_MAX);

  seg_state_e        state;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  period_q;
  logic              cyc_q;
  logic [DIV_W-1:0]  nper_q;
  logic [DIV_W-1:0]  pidx_q;
  logic [SEG_W-1:0]  len_q;
  logic              last_q;
  logic              pend_q;
  logic              halt_q;
  logic              err_q;

  logic              div_go;
  logic [DIV_W-1:0]  div_a;
  logic [DIV_W-1:0]  div_b;
  logic              div_done;
  logic [DIV_W-1:0]  div_quo;

  logic              req_bad;
  logic              halt_eff;
  logic [LEN_W-1:0]  rem_after;
  logic [SEG_W-1:0]  split_len;

  seg_req_check #(
    .LEN_W      (LEN_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_check (
    .addr_low (req_addr[ALIGN_BITS-1:0]),
    .len      (req_len),
    .cyclic   (req_cyclic),
    .period   (req_period),
    .bad      (req_bad)
  );

  seg_divider #(
    .W (DIV_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .done     (div_done),
    .quotient (div_quo)
  );

  always_comb begin
    halt_eff  = cyc_q && (halt_q || cyc_halt);
    rem_after = rem_q - LEN_W'(len_q);
    split_len = SEG_W'(div_quo & ~ALIGN_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      base_q   <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      period_q <= '0;
      cyc_q    <= 1'b0;
      nper_q   <= '0;
      pidx_q   <= '0;
      len_q    <= '0;
      last_q   <= 1'b0;
      pend_q   <= 1'b0;
      halt_q   <= 1'b0;
      err_q    <= 1'b0;
      div_go   <= 1'b0;
      div_a    <= '0;
      div_b    <= '0;
    end else begin
      err_q  <= 1'b0;
      div_go <= 1'b0;
      if (state != ST_IDLE && cyc_halt) begin
        halt_q <= 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          halt_q <= 1'b0;
          if (req_valid) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              base_q   <= req_addr;
              addr_q   <= req_addr;
              cyc_q    <= req_cyclic;
              period_q <= req_period;
              if (req_cyclic) begin
                rem_q  <= req_period;
                div_a  <= DIV_W'(req_len);
                div_b  <= DIV_W'(req_period);
                div_go <= 1'b1;
                state  <= ST_NPER;
              end else begin
                rem_q <= req_len;
                state <= ST_CALC;
              end
            end
          end
        end
        ST_NPER: begin
          if (div_done) begin
            nper_q <= div_quo;
            pidx_q <= '0;
            state  <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (halt_eff) begin
            state <= ST_IDLE;
          end else if (rem_q > SEG_LIMIT) begin
            div_a  <= DIV_W'(rem_q) + SEG_STEP - DIV_W'(1);
            div_b  <= SEG_STEP;
            div_go <= 1'b1;
            state  <= ST_DIV1;
          end else begin
            len_q  <= SEG_W'(rem_q);
            last_q <= !cyc_q;
            pend_q <= cyc_q;
            state  <= ST_EMIT;
          end
        end
        ST_DIV1: begin
          if (div_done) begin
            div_a  <= DIV_W'(rem_q);
            div_b  <= div_quo;
            div_go <= 1'b1;
            state  <= ST_DIV2;
          end
        end
        ST_DIV2: begin
          if (div_done) begin
            len_q  <= split_len;
            last_q <= 1'b0;
            pend_q <= 1'b0;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (seg_ready) begin
            if (!cyc_q) begin
              addr_q <= addr_q + ADDR_W'(len_q);
              rem_q  <= rem_after;
              state  <= (rem_after == '0) ? ST_IDLE : ST_CALC;
            end else if (halt_eff) begin
              state <= ST_IDLE;
            end else if (rem_after == '0) begin
              rem_q <= period_q;
              if (pidx_q == nper_q - DIV_W'(1)) begin
                pidx_q <= '0;
                addr_q <= base_q;
              end else begin
                pidx_q <= pidx_q + DIV_W'(1);
                addr_q <= addr_q + ADDR_W'(len_q);
              end
              state <= ST_CALC;
            end else begin
              rem_q  <= rem_after;
              addr_q <= addr_q + ADDR_W'(len_q);
              state  <= ST_CALC;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign req_err    = err_q;
  assign seg_valid  = (state == ST_EMIT);
  assign seg_addr   = addr_q;
  assign seg_len    = len_q;
  assign seg_last   = last_q;
  assign seg_period = pend_q;

  // R12: an offered segment is held until taken
  p_seg_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=>
      (seg_valid && $stable(seg_addr) && $stable(seg_len) &&
       $stable(seg_last) && $stable(seg_period)));

  // R2: segment lengths stay inside the count field
  p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != '0 && 32'(seg_len) <= SEG_MAX));

  // R4: pieces cut from a larger remainder are aligned
  p_split_align_r4: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_last && !seg_period) |->
      (seg_len[ALIGN_BITS-1:0] == '0));

  // R6: an error pulse only follows a taken request
  p_err_origin_r6: assert property (@(posedge clk) disable iff (rst)
    req_err |-> $past(req_valid && req_ready));

  // R6: a refused request never leads to a segment
  p_err_noseg_r6: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!seg_valid && req_ready));

  // R1: no segment is offered in the cycle after a request was taken
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !seg_valid);

endmodule

// File: tb/tb_seg_splitter.sv
module tb_seg_splitter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [23:0] req_len = '0;
  logic        req_cyclic = 1'b0;
  logic [23:0] req_period = '0;
  logic        cyc_halt = 1'b0;
  logic        req_err;
  logic        seg_valid;
  logic        seg_ready = 1'b1;
  logic [31:0] seg_addr;
  logic [12:0] seg_len;
  logic        seg_last;
  logic        seg_period;

  int nchecks = 0;
  int nerrors = 0;

  always #2.5 clk = ~clk;

  seg_splitter dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_cyclic (req_cyclic),
    .req_period (req_period),
    .cyc_halt   (cyc_halt),
    .req_err    (req_err),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .seg_last   (seg_last),
    .seg_period (seg_period)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_piece(input int r);
    if (r > 8191) begin
      int m;
      m = (r + 8187) / 8188;
      return (r / m) & ~3;
    end
    return r;
  endfunction

  task automatic send_req(input logic [31:0] a, input int len, input bit cyc,
                          input int per, output bit err);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_len    = 24'(len);
    req_cyclic = cyc;
    req_period = 24'(per);
    @(negedge clk);
    req_valid = 1'b0;
    err = req_err;
  endtask

  task automatic pull_seg(output logic [31:0] a, output int l, output bit lst,
                          output bit per);
    bit got;
    int n;
    got = 0;
    n = 0;
    a = '0; l = 0; lst = 0; per = 0;
    while (!got && n < 4000) begin
      @(negedge clk);
      n++;
      if (seg_valid) begin
        got = 1;
        a   = seg_addr;
        l   = int'(seg_len);
        lst = seg_last;
        per = seg_period;
      end
    end
    if (!got) chk(1'b0, "segment timeout", 0, 1);
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (seg_valid) seen = 1;
    end
    chk(!seen && req_ready, tag, seen, 0);
  endtask

  task automatic run_linear(input logic [31:0] a0, input int len, input string len_tag,
                            input bit halt_mid);
    bit err;
    logic [31:0] a;
    int l, r, el, k;
    bit lst, per;
    send_req(a0, len, 1'b0, 0, err);
    chk(!err, "R7 valid linear request not refused", err, 0);
    chk(!req_ready, "R1 busy after accept", req_ready, 0);
    r = len;
    a = a0;
    k = 0;
    while (r > 0) begin
      logic [31:0] ga;
      el = exp_piece(r);
      pull_seg(ga, l, lst, per);
      chk(ga == a, "R5 segment address", ga, a);
      chk(l == el, len_tag, l, el);
      chk(l > 0 && l <= 8191, "R2 length range", l, el);
      chk(lst == (r == el), "R8 last flag", lst, (r == el));
      chk(!per, "R9 no period flag in linear mode", per, 0);
      if (halt_mid && k == 0) begin
        cyc_halt = 1'b1;
        @(negedge clk);
        cyc_halt = 1'b0;
      end
      a = a + 32'(el);
      r = r - el;
      k++;
      if (k > 50) break;
    end
    @(negedge clk);
    chk(req_ready && !seg_valid, "R1 idle after last segment", req_ready, 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(seg_valid == 1'b0, "R2 reset no segment", seg_valid, 0);
    chk(req_err == 1'b0, "R6 reset no error", req_err, 0);
  endtask

  task automatic t_reject(input logic [31:0] a, input int len, input bit cyc,
                          input int per, input string tag);
    bit err;
    send_req(a, len, cyc, per, err);
    chk(err, tag, err, 1);
    @(negedge clk);
    chk(!req_err, {tag, " pulse width"}, req_err, 0);
    expect_quiet(40, {tag, " no segment"});
  endtask

  task automatic t_backpressure;
    bit err;
    logic [31:0] a0, ga;
    int l;
    bit lst, per;
    seg_ready = 1'b0;
    send_req(32'h0000_2000, 12288, 1'b0, 0, err);
    pull_seg(a0, l, lst, per);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(seg_valid && seg_addr == a0 && int'(seg_len) == l && seg_last == lst,
        "R12 held under backpressure", seg_addr, a0);
    chk(!req_ready, "R1 not ready while segment pending", req_ready, 0);
    req_valid = 1'b1;
    req_addr  = 32'h0000_9000;
    req_len   = 24'd16;
    @(negedge clk);
    req_valid = 1'b0;
    chk(a0 == 32'h2000 && l == 6144, "R4 first held piece", l, 6144);
    seg_ready = 1'b1;
    pull_seg(ga, l, lst, per);
    chk(ga == 32'h3800 && l == 6144 && lst, "R5 second piece after release", ga, 32'h3800);
    @(negedge clk);
    expect_quiet(60, "R1 request offered while busy was not taken");
  endtask

  task automatic run_cyclic(input logic [31:0] base, input int size, input int per_len,
                            input int nseg, input string tag);
    bit err;
    int nper, pidx, r, el, l;
    logic [31:0] a, ga;
    bit lst, per;
    send_req(base, size, 1'b1, per_len, err);
    chk(!err, "R7 valid cyclic request not refused", err, 0);
    nper = size / per_len;
    pidx = 0;
    r = per_len;
    a = base;
    for (int k = 0; k < nseg; k++) begin
      el = exp_piece(r);
      pull_seg(ga, l, lst, per);
      chk(ga == a, {tag, " address"}, ga, a);
      chk(l == el, "R9 period split length", l, el);
      chk(per == (r == el), "R9 period flag", per, (r == el));
      chk(!lst, "R8 no last flag in cyclic mode", lst, 0);
      if (k == nseg - 1) begin
        cyc_halt = 1'b1;
        @(negedge clk);
        cyc_halt = 1'b0;
        chk(!seg_valid && req_ready, "R11 halt stops ring", seg_valid, 0);
      end
      r = r - el;
      if (r == 0) begin
        r = per_len;
        if (pidx == nper - 1) begin
          pidx = 0;
          a = base;
        end else begin
          pidx++;
          a = a + 32'(el);
        end
      end else begin
        a = a + 32'(el);
      end
    end
    expect_quiet(80, "R11 nothing after halt");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerrors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_linear(32'h0000_1000, 256, "R3 short request", 1'b0);
    run_linear(32'h0001_0000, 8191, "R3 exact limit", 1'b0);
    run_linear(32'h0002_0000, 8192, "R4 just above limit", 1'b0);
    run_linear(32'h0004_0000, 20480, "R4 three-way split", 1'b0);
    run_linear(32'h0008_0000, 20480, "R11 halt ignored in linear mode", 1'b1);
    t_backpressure();
    t_reject(32'h0000_1002, 16, 1'b0, 0, "R6 misaligned bit1");
    t_reject(32'h0000_1001, 16, 1'b0, 0, "R6 misaligned bit0");
    t_reject(32'h0000_1000, 0, 1'b0, 0, "R7 zero length");
    t_reject(32'h0000_1000, 16, 1'b1, 32, "R7 size below period");
    t_reject(32'h0000_1000, 64, 1'b1, 0, "R7 zero period");
    run_cyclic(32'h0010_0000, 24576, 12288, 9, "R10 split ring");
    run_cyclic(32'h0020_0000, 80, 32, 5, "R10 ring with unused tail");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule